// File: doc/BRIEF.md
# Synchronous Clock-Stop Gating Controller

This block sits between the clock dividers and the output pads of a clock generator. It takes two internal source clocks, one for the processor-side outputs and one for the peripheral-bus outputs. It passes each source clock to a set of outputs, and each output has its own tri-state enable. Two active-low stop requests, one per domain, freeze the outputs that are configured to respond. The block stops and restarts them only while their source clock is low, so an output never shows a shortened or stretched high pulse.

Each stop request passes through a two-flop synchronizer clocked by the domain it gates. The gate enable of each output then updates on the falling edge of its source clock. A stopped processor output goes to high impedance, and for a differential pair both the true and the complement pins float. A stopped peripheral output stays driven low. The bus outputs in the peripheral domain always obey their stop request. The free-running peripheral outputs obey it only when their stop-select bit is set.

Static per-output enable bits and a global disable bit act directly on the tri-state enables. Configuration inputs are plain levels, and bit i of every per-output vector belongs to output i.

Top module: `clk_stop_gate`

## Requirements
- R1: With `cpu_stop_sel[i]`=1, the high pulse of `cpu_t[i]` that starts at rising edge k of `cpu_clk_i` is present exactly when `cpu_halt_n` was high at rising edge k-2. A request first seen low at edge k therefore still lets the pulses at edges k and k+1 through.
- R2: While CPU output i is stopped, `cpu_t_oe[i]` is 0. For a differential output, that is `CPU_DIFF[i]`=1, `cpu_c_oe[i]` is also 0, so both pins of the pair float.
- R3: After `cpu_halt_n` returns high and is seen at rising edge k, a stopped CPU output resumes with a full-width pulse at edge k+2. Its complement is driven high again from the falling edge that follows edge k+1.
- R4: A CPU output with `cpu_stop_sel[i]`=0 keeps toggling and stays enabled whatever `cpu_halt_n` does.
- R5: The high pulse of every `pci_o` output at rising edge k of `pci_clk_i` is present exactly when `pci_halt_n` was high at edge k-2. A stopped `pci_o` output stays driven low, and its `pci_oe` bit is unaffected.
- R6: A `free_o[j]` output follows the R5 timing when `free_stop_sel[j]`=1. When `free_stop_sel[j]`=0 it runs regardless of `pci_halt_n`. Either way it stays driven while stopped.
- R7: No gated output is ever high while its source clock is low.
- R8: Each output's tri-state enable is 0 whenever its enable bit (`cpu_en`, `pci_en`, `free_en`) is 0.
- R9: When `out_dis`=1, every tri-state enable output is 0, whatever state the stop logic is in.
- R10: During and right after reset, with both stop requests high, every output runs, and each enable equals its enable bit while `out_dis`=0.
- R11: For a differential CPU output that is running, `cpu_c` is the inverse of `cpu_t`, and `cpu_c_oe` equals `cpu_t_oe`. A single-ended output has `cpu_c` and `cpu_c_oe` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor-domain source clock |
| pci_clk_i | input | 1 | Peripheral-domain source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_halt_n | input | 1 | Active-low stop request, processor domain |
| pci_halt_n | input | 1 | Active-low stop request, peripheral domain |
| out_dis | input | 1 | Global disable, floats every output |
| cpu_en | input | CPU_N | Per-output enable, processor outputs |
| cpu_stop_sel | input | CPU_N | 1 = output obeys the processor stop request |
| pci_en | input | PCI_N | Per-output enable, bus outputs |
| free_en | input | FREE_N | Per-output enable, free-running outputs |
| free_stop_sel | input | FREE_N | 1 = free-running output obeys the bus stop request |
| cpu_t | output | CPU_N | Gated processor clocks, true phase |
| cpu_t_oe | output | CPU_N | Tri-state enable of cpu_t |
| cpu_c | output | CPU_N | Complement phase (differential outputs only) |
| cpu_c_oe | output | CPU_N | Tri-state enable of cpu_c |
| pci_o | output | PCI_N | Gated bus clocks |
| pci_oe | output | PCI_N | Tri-state enable of pci_o |
| free_o | output | FREE_N | Optionally stoppable bus-domain clocks |
| free_oe | output | FREE_N | Tri-state enable of free_o |

## Verification
A stop or release request appears at a gated output's high pulse two rising source edges after the edge that first sampled it. The gate-enable and complement changes show one falling edge earlier, in the low phase that follows the next rising edge. The bench keeps a two-deep history of the request level seen at each rising edge of each domain. It compares high-phase outputs 1 ns after a rising edge against the entry two edges old, and low-phase outputs 1 ns after a falling edge against the entry one edge old. Configuration changes are applied just after a rising edge, and peripheral stop-select changes are applied only right after a rising edge of that domain. Each falling-edge gate update therefore already uses the values the model assumes.

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int CPU_N  = 2,
  parameter logic [CPU_N-1:0] CPU_DIFF = 2'b01,
  parameter int PCI_N  = 6,
  parameter int FREE_N = 2,
  parameter int SYNC   = 2
) (
  input  logic              cpu_clk_i,
  input  logic              pci_clk_i,
  input  logic              rst_n,
  input  logic              cpu_halt_n,
  input  logic              pci_halt_n,
  input  logic              out_dis,
  input  logic [CPU_N-1:0]  cpu_en,
  input  logic [CPU_N-1:0]  cpu_stop_sel,
  input  logic [PCI_N-1:0]  pci_en,
  input  logic [FREE_N-1:0] free_en,
  input  logic [FREE_N-1:0] free_stop_sel,
  output logic [CPU_N-1:0]  cpu_t,
  output logic [CPU_N-1:0]  cpu_t_oe,
  output logic [CPU_N-1:0]  cpu_c,
  output logic [CPU_N-1:0]  cpu_c_oe,
  output logic [PCI_N-1:0]  pci_o,
  output logic [PCI_N-1:0]  pci_oe,
  output logic [FREE_N-1:0] free_o,
  output logic [FREE_N-1:0] free_oe
);

  logic [SYNC-1:0]   cpu_sync, pci_sync;
  logic              cpu_stop, pci_stop;
  logic [CPU_N-1:0]  cpu_run;
  logic              bus_run;
  logic [FREE_N-1:0] free_run;

  always_ff @(posedge cpu_clk_i or negedge rst_n)
    if (!rst_n) cpu_sync <= '1;
    else        cpu_sync <= {cpu_sync[SYNC-2:0], cpu_halt_n};

  always_ff @(posedge pci_clk_i or negedge rst_n)
    if (!rst_n) pci_sync <= '1;
    else        pci_sync <= {pci_sync[SYNC-2:0], pci_halt_n};

  assign cpu_stop = ~cpu_sync[SYNC-1];
  assign pci_stop = ~pci_sync[SYNC-1];

  always_ff @(negedge cpu_clk_i or negedge rst_n)
    if (!rst_n) cpu_run <= '1;
    else        cpu_run <= ~({CPU_N{cpu_stop}} & cpu_stop_sel);

  always_ff @(negedge pci_clk_i or negedge rst_n)
    if (!rst_n) begin
      bus_run  <= 1'b1;
      free_run <= '1;
    end else begin
      bus_run  <= ~pci_stop;
      free_run <= ~({FREE_N{pci_stop}} & free_stop_sel);
    end

  assign cpu_t    = {CPU_N{cpu_clk_i}} & cpu_run;
  assign cpu_t_oe = cpu_en & cpu_run & {CPU_N{~out_dis}};

  for (genvar i = 0; i < CPU_N; i++) begin : g_cpu
    if (CPU_DIFF[i]) begin : g_diff
      assign cpu_c[i]    = ~cpu_clk_i & cpu_run[i];
      assign cpu_c_oe[i] = cpu_t_oe[i];
    end else begin : g_single
      assign cpu_c[i]    = 1'b0;
      assign cpu_c_oe[i] = 1'b0;
    end
  end

  assign pci_o   = {PCI_N{pci_clk_i & bus_run}};
  assign pci_oe  = pci_en & {PCI_N{~out_dis}};
  assign free_o  = {FREE_N{pci_clk_i}} & free_run;
  assign free_oe = free_en & {FREE_N{~out_dis}};

endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int CPU_N  = 2,
  parameter logic [CPU_N-1:0] CPU_DIFF = 2'b01,
  parameter int PCI_N  = 6,
  parameter int FREE_N = 2
) (
  input logic              cpu_clk_i,
  input logic              pci_clk_i,
  input logic              rst_n,
  input logic              cpu_halt_n,
  input logic              out_dis,
  input logic [CPU_N-1:0]  cpu_en,
  input logic [CPU_N-1:0]  cpu_stop_sel,
  input logic [PCI_N-1:0]  pci_en,
  input logic [FREE_N-1:0] free_en,
  input logic [CPU_N-1:0]  cpu_t,
  input logic [CPU_N-1:0]  cpu_t_oe,
  input logic [CPU_N-1:0]  cpu_c,
  input logic [CPU_N-1:0]  cpu_c_oe,
  input logic [PCI_N-1:0]  pci_o,
  input logic [PCI_N-1:0]  pci_oe,
  input logic [FREE_N-1:0] free_o,
  input logic [FREE_N-1:0] free_oe
);

  logic [1:0] edges;
  always_ff @(posedge cpu_clk_i or negedge rst_n)
    if (!rst_n)           edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;

  for (genvar i = 0; i < CPU_N; i++) begin : g_a
    AST_CPU_STOP_DELAY: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
      (edges == 2'd3 && cpu_en[i] && !out_dis) |-> (cpu_t_oe[i] == !(!$past(cpu_halt_n, 2) && cpu_stop_sel[i]))); // R1
    AST_CPU_KEEP_RUN: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
      (!cpu_stop_sel[i] && cpu_en[i] && !out_dis) |-> cpu_t_oe[i]); // R4
    if (CPU_DIFF[i]) begin : g_d
      AST_PAIR_FLOAT: assert property (@(negedge cpu_clk_i) disable iff (!rst_n)
        cpu_c_oe[i] == cpu_t_oe[i]); // R2
      AST_PAIR_INVERSE: assert property (@(negedge cpu_clk_i) disable iff (!rst_n)
        cpu_t_oe[i] |-> (cpu_c[i] != cpu_t[i])); // R11
    end
  end

  AST_CPU_NO_RUNT: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
    cpu_t == '0); // R7
  AST_PCI_NO_RUNT: assert property (@(posedge pci_clk_i) disable iff (!rst_n)
    (pci_o == '0) && (free_o == '0)); // R7
  AST_PCI_DRIVEN: assert property (@(posedge pci_clk_i) disable iff (!rst_n)
    !out_dis |-> (pci_oe == pci_en && free_oe == free_en)); // R5
  AST_ALL_FLOAT: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
    out_dis |-> (cpu_t_oe == '0 && cpu_c_oe == '0 && pci_oe == '0 && free_oe == '0)); // R9
  AST_EN_GATES: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
    ((cpu_t_oe & ~cpu_en) == '0) && ((pci_oe & ~pci_en) == '0) && ((free_oe & ~free_en) == '0)); // R8

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .CPU_N(CPU_N), .CPU_DIFF(CPU_DIFF), .PCI_N(PCI_N), .FREE_N(FREE_N)
) u_chk (
  .cpu_clk_i(cpu_clk_i), .pci_clk_i(pci_clk_i), .rst_n(rst_n),
  .cpu_halt_n(cpu_halt_n), .out_dis(out_dis),
  .cpu_en(cpu_en), .cpu_stop_sel(cpu_stop_sel), .pci_en(pci_en), .free_en(free_en),
  .cpu_t(cpu_t), .cpu_t_oe(cpu_t_oe), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe),
  .pci_o(pci_o), .pci_oe(pci_oe), .free_o(free_o), .free_oe(free_oe)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;
  localparam int CPU_N = 2, PCI_N = 6, FREE_N = 2;
  localparam logic [CPU_N-1:0] DIFF = 2'b01;

  logic clk = 0, pci_clk = 0, rst_n = 0;
  logic cpu_halt_n = 1, pci_halt_n = 1, out_dis = 0;
  logic [CPU_N-1:0] cpu_en = '1, cpu_stop_sel = 2'b01;
  logic [PCI_N-1:0] pci_en = '1;
  logic [FREE_N-1:0] free_en = '1, free_stop_sel = '0;
  logic [CPU_N-1:0] cpu_t, cpu_t_oe, cpu_c, cpu_c_oe;
  logic [PCI_N-1:0] pci_o, pci_oe;
  logic [FREE_N-1:0] free_o, free_oe;

  int n_chk = 0, n_fail = 0;
  logic [1:0] pc = 0;
  logic h0 = 1, h1 = 1, h2 = 1, p0 = 1, p1 = 1, p2 = 1;
  logic pci_prev = 0, pci_edge = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    if (pc == 2'd2) begin pc <= 0; pci_clk <= ~pci_clk; end
    else pc <= pc + 2'd1;
  end

  clk_stop_gate #(.CPU_N(CPU_N), .CPU_DIFF(DIFF), .PCI_N(PCI_N), .FREE_N(FREE_N)) uut (
    .cpu_clk_i(clk), .pci_clk_i(pci_clk), .rst_n(rst_n),
    .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n), .out_dis(out_dis),
    .cpu_en(cpu_en), .cpu_stop_sel(cpu_stop_sel), .pci_en(pci_en),
    .free_en(free_en), .free_stop_sel(free_stop_sel),
    .cpu_t(cpu_t), .cpu_t_oe(cpu_t_oe), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe),
    .pci_o(pci_o), .pci_oe(pci_oe), .free_o(free_o), .free_oe(free_oe));

  function automatic logic [CPU_N-1:0] cpu_run_exp(logic req_n, logic [CPU_N-1:0] sel);
    return req_n ? '1 : ~sel;
  endfunction
  function automatic logic [FREE_N-1:0] free_run_exp(logic req_n, logic [FREE_N-1:0] sel);
    return req_n ? '1 : ~sel;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_hi();
    logic [CPU_N-1:0] r;
    @(posedge clk); #1;
    h2 = h1; h1 = h0; h0 = cpu_halt_n;
    r = cpu_run_exp(h2, cpu_stop_sel);
    chk(32'(cpu_t), 32'(r), "R1 R3 R4 cpu_t high phase");
    chk(32'(cpu_t_oe), 32'(r & cpu_en & {CPU_N{~out_dis}}), "R2 R8 R9 cpu_t_oe");
    chk(32'(cpu_c), 0, "R11 cpu_c high phase");
    pci_edge = (pci_clk && !pci_prev);
    pci_prev = pci_clk;
    if (pci_edge) begin
      p2 = p1; p1 = p0; p0 = pci_halt_n;
      chk(32'(pci_o), p2 ? 32'(PCI_N'('1)) : 0, "R5 pci_o pulse");
      chk(32'(free_o), 32'(free_run_exp(p2, free_stop_sel)), "R6 free_o pulse");
      chk(32'(pci_oe), 32'(pci_en & {PCI_N{~out_dis}}), "R5 R8 R9 pci_oe");
      chk(32'(free_oe), 32'(free_en & {FREE_N{~out_dis}}), "R6 R8 R9 free_oe");
    end
  endtask

  task automatic step_lo();
    logic [CPU_N-1:0] r;
    @(negedge clk); #1;
    r = cpu_run_exp(h1, cpu_stop_sel);
    chk(32'(cpu_t), 0, "R7 cpu_t low phase");
    chk(32'(cpu_c), 32'(r & DIFF), "R3 R11 cpu_c low phase");
    chk(32'(cpu_c_oe), 32'(r & cpu_en & DIFF & {CPU_N{~out_dis}}), "R2 R11 cpu_c_oe");
    if (!pci_clk) chk(32'({pci_o, free_o}), 0, "R7 pci low phase");
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin step_hi(); step_lo(); end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(32'(cpu_t), 32'(CPU_N'('1)), "R10 cpu_t runs in reset");
    chk(32'({cpu_t_oe, cpu_c_oe}), 32'({cpu_en, cpu_en & DIFF}), "R10 enables in reset");
    @(negedge clk); rst_n = 1;
    pci_prev = pci_clk;
    cyc(8);
    // directed: processor stop, pair stoppable, single-ended free-running (R1 R2 R4)
    step_hi(); cpu_halt_n = 0; step_lo();
    cyc(6);
    step_hi(); cpu_halt_n = 1; step_lo();  // release (R3)
    cyc(6);
    // directed: bus stop, one free output stoppable (R5 R6)
    while (!pci_edge) cyc(1);
    step_hi(); while (!pci_edge) begin step_lo(); step_hi(); end
    free_stop_sel = 2'b10; pci_halt_n = 0; step_lo();
    cyc(40);
    pci_halt_n = 1;
    cyc(30);
    // directed: global disable while stopped (R9)
    step_hi(); cpu_halt_n = 0; step_lo();
    cyc(4);
    step_hi(); out_dis = 1; step_lo();
    cyc(3);
    step_hi(); out_dis = 0; cpu_halt_n = 1; step_lo();
    cyc(6);
    // random
    for (int k = 0; k < 3000; k++) begin
      step_hi();
      if ($urandom_range(5) == 0) cpu_halt_n = ~cpu_halt_n;
      if ($urandom_range(7) == 0) pci_halt_n = ~pci_halt_n;
      if (pci_edge && $urandom_range(5) == 0) begin
        cpu_stop_sel  = CPU_N'($urandom);
        cpu_en        = CPU_N'($urandom) | CPU_N'($urandom);
        pci_en        = PCI_N'($urandom) | PCI_N'($urandom);
        free_en       = FREE_N'($urandom) | FREE_N'($urandom);
        free_stop_sel = FREE_N'($urandom);
        out_dis       = ($urandom_range(7) == 0);
      end
      step_lo();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule